// File: doc/BRIEF.md
# BPSK Symbol Decimator and Hard Slicer

This block is the final stage of a BPSK receiver. It accepts a stream of signed, already downconverted and matched-filtered samples at sixteen samples per symbol. Each sample comes with a valid strobe. Samples may arrive at any rate: one every 625 clocks at the nominal 100 MHz rate, or back to back.

Just after reset, the block discards the samples that fall inside the combined group delay of the transmit shaping filter (96 samples), the receive low-pass filter (128 samples) and the matched filter (96 samples). The first decision point is half of that sum, which is 160. From then on the block keeps one sample in every sixteen. It slices each kept sample by its sign and emits one recovered bit, with a single-cycle valid strobe.

Top module: `bpsk_slicer`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, `bit_valid` is 0 and `bit_out` is 0.
- R2: Counting accepted samples from 1 after reset, samples 1 through 159 never produce a decision.
- R3: The 160th accepted sample is decided, and `bit_valid` is high in the clock cycle that follows its acceptance.
- R4: After the 160th, exactly every 16th accepted sample (176, 192, ...) is decided, and no sample in between is decided.
- R5: A kept sample with bit `DATA_W-1` set (negative two's complement) yields `bit_out` = 0. A positive kept sample yields `bit_out` = 1.
- R6: A kept sample equal to exactly zero yields `bit_out` = 1.
- R7: A cycle with `smp_valid` low neither advances the sample count nor produces a decision, whatever `smp_data` holds at the time.
- R8: `bit_out` holds the most recent decision until the next decision replaces it.
- R9: `bit_valid` is high for exactly one clock per decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | High when `smp_data` holds a sample to accept |
| smp_data | input | DATA_W | Signed matched-filter sample |
| bit_valid | output | 1 | One-cycle strobe marking a new decision |
| bit_out | output | 1 | Recovered bit: 1 for non-negative, 0 for negative |

## Verification
The embedded assertions check four properties on every cycle:
- Each strobe follows an accepted sample.
- The emitted bit is the inverted sign of that sample.
- The strobe never lasts two cycles.
- The bit and the counting state stay frozen through idle cycles.

Some behaviours depend on how many samples have been accepted, so only the bench scenarios can show them. These include the 160-sample skip, the exact 16-sample pick spacing, and the restart of that skip after a reset that arrives mid-stream. The scenarios exercise them with gapped and back-to-back streams, with garbage data on idle cycles, and with the values zero, ±1 and both full-scale extremes.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

    typedef enum logic {
        MODE_SKIP  = 1'b0,
        MODE_TRACK = 1'b1
    } slicer_mode_e;

    // First decision point: half of the summed filter group delays
    function automatic int unsigned first_pick(input int unsigned d_tx,
                                               input int unsigned d_lp,
                                               input int unsigned d_mf);
        return (d_tx + d_lp + d_mf) / 2;
    endfunction

endpackage

// File: rtl/slicer_pick_ctrl.sv
module slicer_pick_ctrl
    import slicer_pkg::*;
#(
    parameter int unsigned SPS       = 16,
    parameter int unsigned FIRST_IDX = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic pick
);
    localparam int unsigned WARM_W = (FIRST_IDX > 1) ? $clog2(FIRST_IDX) : 1;
    localparam int unsigned PH_W   = (SPS > 1) ? $clog2(SPS) : 1;
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(FIRST_IDX - 1);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(SPS - 1);

    typedef struct packed {
        slicer_mode_e      mode;
        logic [WARM_W-1:0] warm;
        logic [PH_W-1:0]   phase;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  pick_d;

    always_comb begin
        st_d   = st_q;
        pick_d = 1'b0;
        if (in_valid) begin
            if (st_q.mode == MODE_SKIP) begin
                if (st_q.warm == WARM_LAST) begin
                    pick_d     = 1'b1;
                    st_d.mode  = MODE_TRACK;
                    st_d.phase = '0;
                end else begin
                    st_d.warm = st_q.warm + 1'b1;
                end
            end else begin
                if (st_q.phase == PH_LAST) begin
                    pick_d     = 1'b1;
                    st_d.phase = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
        end
    end

    assign pick = pick_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SKIP, warm: '0, phase: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Once tracking, the block stays tracking until reset (R4)
    p_track_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TRACK) |=> (st_q.mode == MODE_TRACK));

    // Idle cycles leave the counting state untouched (R7)
    p_idle_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

endmodule

// File: rtl/slicer_sign_dec.sv
module slicer_sign_dec #(
    parameter int unsigned DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] sample,
    output logic              bit_valid,
    output logic              bit_out
);
    typedef struct packed {
        logic vld;
        logic bit_v;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = take;
        if (take) begin
            // Sign bit clear (including exact zero) decides 1
            dec_d.bit_v = ~sample[DATA_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign bit_valid = dec_q.vld;
    assign bit_out   = dec_q.bit_v;

    // Emitted bit is the inverted sign of the taken sample (R5, R6)
    p_bit_from_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_out == !$past(sample[DATA_W-1])));

    // Strobe lasts a single cycle (R9)
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // Output bit holds between decisions (R8)
    p_bit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));

endmodule

// File: rtl/bpsk_slicer.sv
module bpsk_slicer
    import slicer_pkg::*;
#(
    parameter int unsigned DATA_W   = 20,
    parameter int unsigned SPS      = 16,
    parameter int unsigned TX_DELAY = 96,
    parameter int unsigned LP_DELAY = 128,
    parameter int unsigned MF_DELAY = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              bit_valid,
    output logic              bit_out
);
    localparam int unsigned FIRST_IDX = first_pick(TX_DELAY, LP_DELAY, MF_DELAY);

    logic pick;

    slicer_pick_ctrl #(
        .SPS      (SPS),
        .FIRST_IDX(FIRST_IDX)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(smp_valid),
        .pick    (pick)
    );

    slicer_sign_dec #(
        .DATA_W(DATA_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (pick),
        .sample   (smp_data),
        .bit_valid(bit_valid),
        .bit_out  (bit_out)
    );

    // A decision only ever follows an accepted sample (R7)
    p_strobe_needs_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(smp_valid));

    // Right after reset release nothing is decided yet (R1)
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!bit_valid && !bit_out));

endmodule

// File: tb/bpsk_slicer_test.sv
module bpsk_slicer_test;
    localparam int W     = 20;
    localparam int SPS   = 16;
    localparam int FIRST = 160;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         bit_valid;
    logic         bit_out;

    int     checks = 0;
    int     failures = 0;
    int     n_sent = 0;
    int     n_pick = 0;
    int     n_seen = 0;
    logic   exp_q[$];
    logic   last_bit = 1'b0;
    logic   prev_bv = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #4 clk = ~clk;

    bpsk_slicer uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bit_valid(bit_valid), .bit_out(bit_out)
    );

    function automatic logic [W-1:0] noise();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[W-1:0];
    endfunction

    function automatic bit is_pick(input int n);
        return (n == FIRST) || (n > FIRST && ((n - FIRST) % SPS) == 0);
    endfunction

    // Value for a decided sample: cycles through corner values
    function automatic logic [W-1:0] pick_value(input int k);
        case (k % 6)
            0: return '0;                          // zero -> 1 (R6)
            1: return W'(1);                       // +1 -> 1
            2: return '1;                          // -1 -> 0
            3: return {1'b0, {(W-1){1'b1}}};       // max positive
            4: return {1'b1, {(W-1){1'b0}}};       // min negative
            default: return noise();
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Driver: one accepted sample followed by gap idle cycles
    task automatic send(input int gap);
        logic [W-1:0] v;
        @(negedge clk);
        n_sent++;
        if (is_pick(n_sent)) begin
            v = pick_value(n_pick);
            n_pick++;
            exp_q.push_back(~v[W-1]);
        end else begin
            v = noise();
        end
        smp_valid = 1'b1;
        smp_data  = v;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = noise();     // garbage while idle (R7)
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = noise();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        @(negedge clk);
        check(bit_valid == 1'b0 && bit_out == 1'b0, "R1", {bit_valid, bit_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        n_sent = 0;
        n_seen = 0;
        last_bit = 1'b0;
        @(negedge clk);
        check(bit_valid == 1'b0 && bit_out == 1'b0, "R1", {bit_valid, bit_out}, 0);
    endtask

    // Monitor: pops expected bits as decisions appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                n_seen++;
                check(!prev_bv, "R9", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R4 unexpected decision", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(bit_out == e, "R5/R6 bit value", bit_out, e);
                    last_bit = e;
                end
            end else begin
                check(bit_out == last_bit, "R8", bit_out, last_bit);
            end
            prev_bv = bit_valid;
        end else begin
            prev_bv = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        smp_data = noise();
        do_reset();

        // Gapped stream through the skip window (R2, R7)
        for (int i = 0; i < FIRST - 1; i++) send(i % 4);
        idle(3);
        check(n_seen == 0, "R2 no decision before sample 160", n_seen, 0);

        // Sample 160 and its strobe timing (R3)
        send(0);
        @(negedge clk);
        smp_valid = 1'b0;
        check(bit_valid == 1'b1, "R3 strobe after sample 160", bit_valid, 1);
        idle(2);

        // Tracking with gaps (R4, R5, R6)
        for (int i = 0; i < SPS * 20; i++) send(i % 3);
        // Back-to-back samples (R4, R9)
        for (int i = 0; i < SPS * 10; i++) send(0);
        idle(4);
        check(exp_q.size() == 0, "R4 all picks decided", exp_q.size(), 0);
        check(n_seen == 31, "R4 decision count", n_seen, 31);

        // Mid-stream reset restarts the skip window (R1, R2)
        for (int i = 0; i < 7; i++) send(1);
        idle(3);
        do_reset();
        for (int i = 0; i < FIRST - 1; i++) send(1);
        idle(3);
        check(n_seen == 0, "R2 skip restarts after reset", n_seen, 0);
        for (int i = 0; i < SPS * 8 + 1; i++) send(2);
        idle(4);
        check(exp_q.size() == 0, "R4 all picks decided after reset", exp_q.size(), 0);
        check(n_seen == 9, "R3/R4 decision count after reset", n_seen, 9);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule